// File: doc/BRIEF.md
# Inverter Fault and Restart Controller

This block sits between the motor-control logic and the six gate drivers of a three-phase inverter bridge. It passes each high-side and low-side gate command through to its gate output and watches several protection inputs: an over-current comparator bit, a low-side supply undervoltage bit, one supply undervoltage bit per high-side driver, and the sensed level of the shared open-drain fault pin.

Every protection event has its own effect. An over-current event outside the blanking window, or a low-side undervoltage, starts the fault sequence. The sequence pulls the active-low fault flag, raises the global gate-disable and holds it while the cause persists. It then counts a clear time in clock-enable ticks before it lets go by itself. A high-side undervoltage turns off only its own phase and does not touch the fault flag. An outside pull-down on the fault pin disables every gate for as long as it lasts.

After reset, and after any disable, a gate output turns on only after its command goes low and then high again. A command that is held high through a fault therefore never restarts the bridge on its own. Over-current is ignored for a blanking window that opens whenever a low-side gate output rises, so turn-on spikes do not trip it.

Top module: `inv_fault_ctrl`

## Requirements
- R1: An armed and enabled gate output equals its command one clock after the command is applied.
- R2: When both commands of one phase are high, both gate outputs of that phase are low.
- R3: `oc_trip` is ignored for BLANK_CYC clock cycles, starting in the cycle in which any low-side gate output becomes 1.
- R4: `oc_trip` high in a cycle outside the blanking window drives `fault_n` low and `gate_off` high from the next cycle. All six gate outputs are low one cycle after that.
- R5: Once every cause has ended, `fault_n` returns high after CLR_TICKS cycles in which `tick` is 1. It stays low for as long as `tick` stays 0. With `tick` held at 1, it rises CLR_TICKS+1 cycles after the last cycle in which a cause was present.
- R6: `ls_uv` high drives `fault_n` low from the next cycle, and it stays low for the whole time `ls_uv` is high. All gates are off during this time.
- R7: `hs_uv[i]` high turns off both gates of phase i from the next cycle. The other phases keep running and `fault_n` stays high.
- R8: After reset, and after any disable, a gate output stays low until its command has gone from 0 to 1. A command that stays high throughout is ignored.
- R9: `flt_pin_in` at 0 raises `gate_off` in the same cycle and forces all gates low from the next cycle. It does not change `fault_n`.
- R10: During and right after reset, all gate outputs and `gate_off` are 0 and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Clock-enable pulse that times the clear interval |
| oc_trip | input | 1 | Over-current comparator output, 1 = over limit |
| ls_uv | input | 1 | Low-side supply undervoltage, 1 = under |
| hs_uv | input | NPH | Per-phase high-side supply undervoltage, 1 = under |
| flt_pin_in | input | 1 | Sensed level of the fault pin, 0 = pulled low |
| hi_cmd | input | NPH | High-side gate commands, active high |
| lo_cmd | input | NPH | Low-side gate commands, active high |
| hi_gate | output | NPH | High-side gate outputs |
| lo_gate | output | NPH | Low-side gate outputs |
| fault_n | output | 1 | Fault flag, 0 = fault active |
| gate_off | output | 1 | Global gate disable, 1 = all gates forced off |

## Verification
The gate outputs follow their commands, a high-side undervoltage and a fault-pin pull-down after one clock. `gate_off` responds to the pin in the same cycle. `fault_n` falls one clock after an accepted over-current or a low-side undervoltage, and the gates drop one clock later still. The bench drives inputs on the falling edge and samples exactly that number of falling edges later. For the clear interval it counts cycles until `fault_n` rises and compares the count with CLR_TICKS. The blanking window is probed with an over-current level held across all of its cycles, followed by a single pulse just after it.

// File: rtl/inv_fault_pkg.sv
// Package: shared types for the inverter fault controller.
// Assumes: nothing beyond IEEE 1800-2017.
package inv_fault_pkg;
    // Fault sequencer states.
    typedef enum logic [1:0] {
        FS_RUN   = 2'd0,
        FS_HOLD  = 2'd1,
        FS_CLEAR = 2'd2
    } flt_state_t;
endpackage

// File: rtl/oc_blanker.sv
// Module: oc_blanker
// Opens a blanking window of BLANK_CYC cycles in the cycle in which any
// low-side gate output rises, and passes oc_trip on only outside it.
// Assumes: lo_gate is a registered signal; BLANK_CYC >= 1.
module oc_blanker #(
    parameter int NPH       = 3,
    parameter int BLANK_CYC = 100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] lo_gate,
    input  logic           oc_trip,
    output logic           oc_hit
);
    localparam int BW = $clog2(BLANK_CYC + 1);

    logic [NPH-1:0] lo_q;
    logic [BW-1:0]  cnt;
    logic           rise;
    logic           blank;

    // Detect a new low-side turn-on and merge it with the running window.
    always_comb begin
        rise  = |(lo_gate & ~lo_q);
        blank = rise | (cnt != '0);
        oc_hit = oc_trip & ~blank;
    end

    // Track low-side outputs and count down the rest of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            cnt  <= '0;
        end else begin
            lo_q <= lo_gate;
            if (rise)
                cnt <= BW'(BLANK_CYC - 1);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/flt_sequencer.sv
// Module: flt_sequencer
// Holds the fault while a cause is present, then counts CLR_TICKS ticks
// with no cause before it returns to run. A cause during counting restarts it.
// Assumes: oc_hit is already blanked; ls_uv and oc_trip are synchronous.
module flt_sequencer
    import inv_fault_pkg::*;
#(
    parameter int CLR_TICKS = 18000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic oc_hit,
    input  logic oc_trip,
    input  logic ls_uv,
    output logic fault_n
);
    localparam int CW = (CLR_TICKS > 1) ? $clog2(CLR_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLR_TICKS - 1);

    flt_state_t    state;
    logic [CW-1:0] cnt;
    logic          cause;

    // A fault persists while the comparator or the low-side supply is bad.
    assign cause   = oc_trip | ls_uv;
    assign fault_n = (state == FS_RUN);

    // State and clear-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_RUN;
            cnt   <= '0;
        end else begin
            case (state)
                FS_RUN: begin
                    if (oc_hit | ls_uv) state <= FS_HOLD;
                end
                FS_HOLD: begin
                    if (!cause) begin
                        state <= FS_CLEAR;
                        cnt   <= '0;
                    end
                end
                FS_CLEAR: begin
                    if (cause) begin
                        state <= FS_HOLD;
                    end else if (tick) begin
                        if (cnt == LAST) state <= FS_RUN;
                        else             cnt   <= cnt + 1'b1;
                    end
                end
                default: state <= FS_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/phase_gate.sv
// Module: phase_gate
// One inverter leg: registers the two gate outputs, blocks shoot-through
// and re-arms each gate only on a fresh rising edge of its command.
// Assumes: dis is high whenever this leg must be off.
module phase_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic dis,
    input  logic hi_cmd,
    input  logic lo_cmd,
    output logic hi_gate,
    output logic lo_gate
);
    logic hi_q, lo_q, hi_arm, lo_arm;
    logic hi_arm_nx, lo_arm_nx;

    // An arm survives while enabled; a command rising edge sets it.
    always_comb begin
        hi_arm_nx = ~dis & (hi_arm | (hi_cmd & ~hi_q));
        lo_arm_nx = ~dis & (lo_arm | (lo_cmd & ~lo_q));
    end

    // Register command history, arms and gate outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= 1'b1;
            lo_q    <= 1'b1;
            hi_arm  <= 1'b0;
            lo_arm  <= 1'b0;
            hi_gate <= 1'b0;
            lo_gate <= 1'b0;
        end else begin
            hi_q    <= hi_cmd;
            lo_q    <= lo_cmd;
            hi_arm  <= hi_arm_nx;
            lo_arm  <= lo_arm_nx;
            hi_gate <= hi_arm_nx & hi_cmd & ~lo_cmd;
            lo_gate <= lo_arm_nx & lo_cmd & ~hi_cmd;
        end
    end
endmodule

// File: rtl/inv_fault_ctrl.sv
// Module: inv_fault_ctrl (top)
// Collects the protection inputs of a three-phase gate driver, runs the
// fault sequence and gates the six outputs.
// Assumes: all inputs are synchronous to clk; tick is a one-cycle enable.
module inv_fault_ctrl #(
    parameter int NPH       = 3,
    parameter int BLANK_CYC = 100,
    parameter int CLR_TICKS = 18000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           oc_trip,
    input  logic           ls_uv,
    input  logic [NPH-1:0] hs_uv,
    input  logic           flt_pin_in,
    input  logic [NPH-1:0] hi_cmd,
    input  logic [NPH-1:0] lo_cmd,
    output logic [NPH-1:0] hi_gate,
    output logic [NPH-1:0] lo_gate,
    output logic           fault_n,
    output logic           gate_off
);
    logic oc_hit;

    // Over-current filter keyed to low-side turn-on.
    oc_blanker #(.NPH(NPH), .BLANK_CYC(BLANK_CYC)) u_blank (
        .clk(clk), .rst_n(rst_n), .lo_gate(lo_gate),
        .oc_trip(oc_trip), .oc_hit(oc_hit)
    );

    // Fault hold and timed clear.
    flt_sequencer #(.CLR_TICKS(CLR_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .oc_hit(oc_hit),
        .oc_trip(oc_trip), .ls_uv(ls_uv), .fault_n(fault_n)
    );

    // Global disable: internal fault or an outside pull on the pin.
    assign gate_off = ~fault_n | ~flt_pin_in;

    // One leg per phase, each also stopped by its own supply monitor.
    for (genvar i = 0; i < NPH; i++) begin : g_leg
        phase_gate u_leg (
            .clk(clk), .rst_n(rst_n), .dis(gate_off | hs_uv[i]),
            .hi_cmd(hi_cmd[i]), .lo_cmd(lo_cmd[i]),
            .hi_gate(hi_gate[i]), .lo_gate(lo_gate[i])
        );
    end
endmodule

// File: rtl/inv_fault_ctrl_chk.sv
// Module: inv_fault_ctrl_chk
// Clocked properties on the ports of inv_fault_ctrl, attached by bind.
module inv_fault_ctrl_chk #(
    parameter int NPH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ls_uv,
    input logic [NPH-1:0] hs_uv,
    input logic           flt_pin_in,
    input logic [NPH-1:0] hi_cmd,
    input logic [NPH-1:0] hi_gate,
    input logic [NPH-1:0] lo_gate,
    input logic           fault_n,
    input logic           gate_off
);
    p_gate_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((hi_gate & ~$past(hi_cmd)) == '0));

    p_no_shoot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_gate & lo_gate) == '0));

    p_off_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |=> ((hi_gate == '0) && (lo_gate == '0)));

    p_lsuv_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ls_uv |=> !fault_n);

    p_hsuv_leg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_uv != '0) |=> (((hi_gate | lo_gate) & $past(hs_uv)) == '0));

    p_pin_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_pin_in |-> gate_off);
endmodule

bind inv_fault_ctrl inv_fault_ctrl_chk #(.NPH(NPH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ls_uv(ls_uv), .hs_uv(hs_uv),
    .flt_pin_in(flt_pin_in), .hi_cmd(hi_cmd), .hi_gate(hi_gate),
    .lo_gate(lo_gate), .fault_n(fault_n), .gate_off(gate_off)
);

// File: tb/test_inv_fault_ctrl.sv
`timescale 1ns/1ps
module test_inv_fault_ctrl;
    localparam int NPH = 3;
    localparam int BLK = 4;
    localparam int CLR = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, oc_trip = 1'b0, ls_uv = 1'b0, flt_pin_in = 1'b1;
    logic [NPH-1:0] hs_uv = '0, hi_cmd = '1, lo_cmd = '1;
    logic [NPH-1:0] hi_gate, lo_gate;
    logic fault_n, gate_off;
    int checks = 0, errors = 0, cyc = 0;

    always #10 clk = ~clk;

    inv_fault_ctrl #(.NPH(NPH), .BLANK_CYC(BLK), .CLR_TICKS(CLR)) i_inv_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .oc_trip(oc_trip), .ls_uv(ls_uv),
        .hs_uv(hs_uv), .flt_pin_in(flt_pin_in), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .hi_gate(hi_gate), .lo_gate(lo_gate), .fault_n(fault_n), .gate_off(gate_off)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [NPH-1:0] eh, input logic [NPH-1:0] el,
                           input logic ef, input logic eo);
        chk(req, {hi_gate, lo_gate, fault_n, gate_off}, {eh, el, ef, eo});
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        step(3);
        chk_out("R10 reset", '0, '0, 1'b1, 1'b0);
        rst_n = 1'b1;
        step(3);
        chk_out("R8 held commands after reset", '0, '0, 1'b1, 1'b0);

        // Arm all gates with fresh edges.
        hi_cmd = '0; lo_cmd = '0; step(1);
        hi_cmd = '1; step(1);
        chk_out("R8 high edges arm", '1, '0, 1'b1, 1'b0);
        hi_cmd = '0; lo_cmd = '1; step(1);
        chk_out("R8 low edges arm", '0, '1, 1'b1, 1'b0);

        // Sweep every command combination.
        for (int v = 0; v < 64; v++) begin
            hi_cmd = v[2:0]; lo_cmd = v[5:3];
            step(1);
            chk_out("R1 R2 sweep", v[2:0] & ~v[5:3], v[5:3] & ~v[2:0], 1'b1, 1'b0);
        end

        // Blanking window after a low-side rise.
        hi_cmd = '0; lo_cmd = '0; step(8);
        hi_cmd = 3'b010; lo_cmd = 3'b001; step(1);
        oc_trip = 1'b1; step(BLK);
        oc_trip = 1'b0;
        chk_out("R3 blanked trip", 3'b010, 3'b001, 1'b1, 1'b0);
        step(2);
        chk_out("R3 still running", 3'b010, 3'b001, 1'b1, 1'b0);

        // Accepted trip.
        oc_trip = 1'b1; tick = 1'b0; step(1);
        oc_trip = 1'b0;
        chk_out("R4 flag next cycle", 3'b010, 3'b001, 1'b0, 1'b1);
        step(1);
        chk_out("R4 gates off", '0, '0, 1'b0, 1'b1);
        step(20);
        chk_out("R5 no ticks holds fault", '0, '0, 1'b0, 1'b1);
        tick = 1'b1;
        n = 0;
        for (int k = 1; k <= CLR + 4; k++) begin
            step(1);
            if (n == 0 && fault_n) n = k;
        end
        chk("R5 clear length", n, CLR);
        chk_out("R8 no restart on held command", '0, '0, 1'b1, 1'b0);
        hi_cmd = '0; lo_cmd = '0; step(1);
        hi_cmd = 3'b010; lo_cmd = 3'b001; step(1);
        chk_out("R8 restart on edge", 3'b010, 3'b001, 1'b1, 1'b0);

        // Low-side undervoltage.
        ls_uv = 1'b1; step(1);
        chk_out("R6 flag next cycle", 3'b010, 3'b001, 1'b0, 1'b1);
        for (int k = 0; k < 9; k++) begin
            step(1);
            chk_out("R6 held during undervoltage", '0, '0, 1'b0, 1'b1);
        end
        ls_uv = 1'b0; step(CLR);
        chk("R6 R5 before clear", fault_n, 1'b0);
        step(1);
        chk("R6 R5 after clear", fault_n, 1'b1);

        // High-side undervoltage on phase 1.
        hi_cmd = '0; lo_cmd = '0; step(1);
        hi_cmd = 3'b011; lo_cmd = 3'b100; step(1);
        chk_out("R1 re-armed", 3'b011, 3'b100, 1'b1, 1'b0);
        hs_uv = 3'b010; step(1);
        chk_out("R7 only phase 1 off", 3'b001, 3'b100, 1'b1, 1'b0);
        hs_uv = '0; step(3);
        chk_out("R7 R8 stays off", 3'b001, 3'b100, 1'b1, 1'b0);
        hi_cmd = 3'b001; step(1);
        hi_cmd = 3'b011; step(1);
        chk_out("R8 phase 1 back", 3'b011, 3'b100, 1'b1, 1'b0);

        // Outside pull on the fault pin.
        flt_pin_in = 1'b0; #1;
        chk("R9 same-cycle disable", gate_off, 1'b1);
        step(1);
        chk_out("R9 all off", '0, '0, 1'b1, 1'b1);
        flt_pin_in = 1'b1; step(2);
        chk_out("R9 R8 no restart", '0, '0, 1'b1, 1'b0);
        hi_cmd = '0; lo_cmd = '0; step(1);
        hi_cmd = 3'b100; lo_cmd = 3'b011; step(1);
        chk_out("R1 after pin release", 3'b100, 3'b011, 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule